// File: doc/BRIEF.md
# Processor Reset Synchronizer

This block turns an active-low reset request into the active-high reset that a processor core samples. The request may be pulled low by a power-on RC network or by a push-button; a Schmitt-trigger stage ahead of this block has already cleaned up the slow edge. The block does not time the length of the reset pulse. The external network holds the request low long enough.

A short chain of flip-flops clocked on the falling edge of the processor clock carries the request to the output. The output therefore only changes half a cycle before the rising edge on which the processor samples it, and the processor always sees a settled level. The chain length is a parameter from 2 to 4. The default of 2 gives protection against metastability and keeps assertion and release of reset inside a four-clock bound. The chain holds reset asserted from power-up, so the processor is in reset before the first clock edge arrives.

Top module: `cpu_reset_sync`

## Requirements
- R1: Before any clock edge has occurred, the reset output is high (asserted).
- R2: The request is active low and the output is active high: a request held low gives an output of 1, and a request held high gives an output of 0.
- R3: The reset output changes value only at a falling edge of the clock. It never changes while the clock is high.
- R4: When the request is low at a falling edge, the output is high at the STAGES-th falling edge, counting that edge as the first. STAGES is at most 4, so reset asserts within 4 clocks.
- R5: Release follows the same timing as R4. A request that goes high at a falling edge drops the output at the STAGES-th falling edge, counting that edge as the first.
- R6: The output is the request's inverted value at falling edges, delayed and with no filtering. A request low at exactly one falling edge produces exactly one clock period of high output. A rise or fall of the output always has a matching request level that was sampled within the previous STAGES falling edges.
- R7: The STAGES parameter must lie between 2 and 4. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock; the chain is clocked on its falling edge |
| rst_req_n_i | input | 1 | Reset request, active low, already Schmitt-conditioned |
| cpu_rst_o | output | 1 | Reset to the processor, active high, updated on falling edges |

## Verification
A corrupted stage in the chain shows up at the output as a wrong level within STAGES falling edges. Either the reset drops while the request is still low, or the reset lingers after the request has stayed high for STAGES edges. A wrong clock edge or a missing stage shows up as a change of output during the high phase of the clock, or as a latency count other than STAGES. The bench checks the output half a cycle after each falling edge against a history of the request it records itself. A wrong state is therefore reported in the first cycle it reaches the pin.

// File: rtl/rstsync_pkg.sv
package rstsync_pkg;

  // Upper bound on the request-to-reset latency, in clocks.
  localparam int unsigned MaxLatencyClks = 4;
  localparam int unsigned MinStages      = 2;

  // Width of the saturating history counters.
  localparam int unsigned RunW = $clog2(MaxLatencyClks + 1);
  typedef logic [RunW-1:0] run_t;

  // Saturating step: clear to zero on a hit, otherwise count up to limit.
  function automatic run_t sat_step(input run_t cnt, input logic clear, input run_t limit);
    if (clear) begin
      return '0;
    end else if (cnt >= limit) begin
      return limit;
    end else begin
      return cnt + run_t'(1);
    end
  endfunction

  // Stage count is legal when the latency stays inside the bound.
  function automatic bit stages_ok(input int unsigned n);
    return (n >= MinStages) && (n <= MaxLatencyClks);
  endfunction

endpackage

// File: rtl/rstsync_chain.sv
module rstsync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              d_i,
  output logic [STAGES-1:0] stage_o
);

  // Power-up value: every stage holds reset asserted.
  logic [STAGES-1:0] stage_q = '1;

  always_ff @(negedge clk_i) begin
    stage_q[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(negedge clk_i) begin
      stage_q[k] <= stage_q[k-1];
    end
  end

  assign stage_o = stage_q;

endmodule

// File: rtl/rstsync_tracker.sv
module rstsync_tracker
  import rstsync_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic req_n_i,
  output run_t low_run_o,
  output run_t high_run_o,
  output run_t since_low_o,
  output run_t since_high_o,
  output logic settled_o
);

  localparam run_t Limit = run_t'(STAGES);

  run_t low_run_q    = '0;
  run_t high_run_q   = '0;
  run_t since_low_q  = Limit;
  run_t since_high_q = Limit;
  run_t edges_q      = '0;

  always_ff @(negedge clk_i) begin
    low_run_q    <= sat_step(low_run_q,    req_n_i,  Limit);
    high_run_q   <= sat_step(high_run_q,   !req_n_i, Limit);
    since_low_q  <= sat_step(since_low_q,  !req_n_i, Limit);
    since_high_q <= sat_step(since_high_q, req_n_i,  Limit);
    edges_q      <= sat_step(edges_q,      1'b0,     Limit);
  end

  assign low_run_o    = low_run_q;
  assign high_run_o   = high_run_q;
  assign since_low_o  = since_low_q;
  assign since_high_o = since_high_q;
  assign settled_o    = (edges_q == Limit);

endmodule

// File: rtl/cpu_reset_sync.sv
module cpu_reset_sync
  import rstsync_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_req_n_i,
  output logic cpu_rst_o
);

  localparam run_t Limit = run_t'(STAGES);

  if (!stages_ok(STAGES)) begin : g_bad_stages
    $error("cpu_reset_sync: STAGES out of range");  // R7
  end

  // Request converted to active-high before it enters the chain.
  logic              req_active;
  logic [STAGES-1:0] stage_vec;

  assign req_active = ~rst_req_n_i;

  rstsync_chain #(.STAGES(STAGES)) u_chain (
    .clk_i   (clk_i),
    .d_i     (req_active),
    .stage_o (stage_vec)
  );

  assign cpu_rst_o = stage_vec[STAGES-1];

  // Named history of the request, used only by the checks below.
  run_t low_run;
  run_t high_run;
  run_t since_low;
  run_t since_high;
  logic settled;

  rstsync_tracker #(.STAGES(STAGES)) u_track (
    .clk_i        (clk_i),
    .req_n_i      (rst_req_n_i),
    .low_run_o    (low_run),
    .high_run_o   (high_run),
    .since_low_o  (since_low),
    .since_high_o (since_high),
    .settled_o    (settled)
  );

  AST_ASSERT_BOUND: assert property (@(negedge clk_i) disable iff (!settled)
    (low_run >= Limit) |-> cpu_rst_o);  // R4

  AST_RELEASE_BOUND: assert property (@(negedge clk_i) disable iff (!settled)
    (high_run >= Limit) |-> !cpu_rst_o);  // R5

  AST_RISE_HAS_CAUSE: assert property (@(negedge clk_i) disable iff (!settled)
    $rose(cpu_rst_o) |-> (since_low < Limit));  // R6

  AST_FALL_HAS_CAUSE: assert property (@(negedge clk_i) disable iff (!settled)
    $fell(cpu_rst_o) |-> (since_high < Limit));  // R6

  always @(cpu_rst_o) begin
    if (settled) begin
      AST_CHANGE_ON_FALL: assert (!clk_i) else $error("reset changed in high phase");  // R3
    end
  end

endmodule

// File: tb/test_cpu_reset_sync.sv
module test_cpu_reset_sync;

  localparam int unsigned STAGES = 2;
  localparam int unsigned PERIOD = 4;

  logic clk = 1'b0;
  logic req_n = 1'b0;
  logic rst_out;

  int tests = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  cpu_reset_sync #(.STAGES(STAGES)) i_cpu_reset_sync (
    .clk_i       (clk),
    .rst_req_n_i (req_n),
    .cpu_rst_o   (rst_out)
  );

  // Request as seen at each falling edge, newest first.
  logic hist [0:3];
  int   nsamp = 0;

  always @(negedge clk) begin
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = req_n;
    nsamp++;
  end

  function automatic logic expect_out();
    if (nsamp < STAGES) return 1'b1;
    return !hist[STAGES-1];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("[TB] FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: sample at posedge+1 against the model, then drive.
  task automatic step(input logic nxt, input string tag);
    @(posedge clk); #1;
    check(tag, rst_out, expect_out());
    req_n = nxt;
  endtask

  // Drive a level and count cycles until the output reaches target.
  task automatic latency(input logic drive, input logic target, output int n);
    @(posedge clk); #1;
    req_n = drive;
    n = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); #1;
      if (rst_out == target) begin n = k; break; end
    end
  endtask

  // R3: output must never move in the high phase of the clock.
  always @(rst_out) begin
    if ($time > 0) begin
      tests++;
      if (clk !== 1'b0) begin
        fails++;
        $display("[TB] FAIL R3: output changed with clk %b expected 0 at %0t", clk, $time);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("[TB] FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int highs;
    void'($urandom(32'd1357));
    #1;
    check("R1 power-up", rst_out, 1'b1);

    // R2: held request gives asserted reset.
    for (int i = 0; i < 6; i++) step(1'b0, "R2 held low");
    check("R2 steady low", rst_out, 1'b1);

    // R5: release latency.
    latency(1'b1, 1'b0, n);
    check_int("R5 release latency", n, STAGES);
    for (int i = 0; i < 4; i++) step(1'b1, "R2 held high");
    check("R2 steady high", rst_out, 1'b0);

    // R4: assertion latency within bound.
    latency(1'b0, 1'b1, n);
    check_int("R4 assert latency", n, STAGES);
    tests++;
    if (n > 4 || n == 0) begin
      fails++;
      $display("[TB] FAIL R4: latency actual %0d expected <= 4", n);
    end

    // R6: single-edge pulse gives exactly one cycle of reset.
    for (int i = 0; i < 4; i++) step(1'b1, "R6 idle");
    @(posedge clk); #1; req_n = 1'b0;
    @(posedge clk); #1; req_n = 1'b1;
    highs = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (rst_out) highs++;
    end
    check_int("R6 pulse width", highs, 1);

    // R2/R6: random request pattern against the history model.
    for (int i = 0; i < 500; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      if ((i % 50) < 10) v = $urandom % 2;
      step(v, "R6 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule